// File: doc/BRIEF.md
# Multilane Phase Error Aggregator

This block sits between four receive lanes and a shared clock recovery loop. Every update interval, each lane reports two numbers from its bang-bang phase detector. The first is the net count of early/late votes, signed. The second is how many data transitions it saw. The block decodes the compact lane encoding and adds the votes and the transitions across all lanes. It divides the summed votes by the summed transitions and scales the quotient by a programmable proportional gain. The result is one signed, saturated phase-error word.

Votes are summed before the division. A timing shift that every lane sees therefore appears at full weight. A disturbance confined to one lane appears at a quarter of that weight. Dividing by the transition count makes the result depend only on the vote density, not on how busy the data was. The gain multiply and the division share one combinational stage that ends in the output register, so a result is ready on the clock edge right after the lanes are presented. The loop presents lane data once per update period of eight oscillator cycles.

Top module: `pae_phase_aggregator`

## Requirements
- R1: A synchronous active-high reset clears `err_valid` to 0 and `err_word` to 0 on the next clock edge.
- R2: Each lane vote field is SUM_W bits (default 6) in sign-magnitude form. The top bit set means negative, and the lower SUM_W-1 bits are the magnitude. A negative zero is decoded as zero. Lane i occupies bits [i*SUM_W +: SUM_W] of `lane_sum`, and its unsigned count occupies bits [i*CNT_W +: CNT_W] of `lane_cnt`.
- R3: Votes and counts are added over all lanes before the division. An equal vote on all four lanes gives four times the result of the same vote on one lane when total transitions are equal.
- R4: With S the summed votes, C the summed counts and G the unsigned gain, `err_word` equals S*G*2^FRAC_W/C (FRAC_W default 3), truncated toward zero.
- R5: The result depends only on the ratio of S to C. For example, 2 votes in 10 transitions gives the same word as 20 votes in 100 transitions.
- R6: The magnitude saturates at 2^(OUT_W-1)-1 (127 by default), symmetrically for both signs, so the most negative code never appears.
- R7: When C is zero, `err_word` becomes 0 and `err_valid` is still asserted.
- R8: `err_valid` is a one-cycle pulse on the clock edge after each cycle with `in_valid` high. `err_word` updates on that same edge.
- R9: While `in_valid` is low, lane inputs and gain are ignored. `err_word` keeps its value and `err_valid` stays low.
- R10: A gain of zero gives a zero result for any nonzero count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Lane data and gain are present this cycle |
| lane_sum | input | LANES*SUM_W | Packed sign-magnitude vote sums, lane 0 in the low bits |
| lane_cnt | input | LANES*CNT_W | Packed unsigned transition counts, lane 0 in the low bits |
| gain | input | GAIN_W | Unsigned proportional gain |
| err_valid | output | 1 | One-cycle strobe marking a new result |
| err_word | output | OUT_W | Signed normalized and scaled phase error |

## Verification
The assertions assume that `in_valid` comes as isolated one-cycle strobes. The single-pulse and hold properties are written against that pattern. The saturation and sign properties assume that lane magnitudes stay within the encoding. The stimulus drives one strobe per eight-cycle update period on the falling clock edge. It keeps every lane field inside its width, and it changes inputs only between strobes to show that idle cycles leave the output untouched.

// File: rtl/pae_pkg.sv
`timescale 1ns/1ps
package pae_pkg;
  // Extra bits needed when summing n equal-width terms.
  function automatic int unsigned grow_bits(input int unsigned n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction
endpackage

// File: rtl/pae_lane_decode.sv
`timescale 1ns/1ps
module pae_lane_decode #(
  parameter int LANES = 4,
  parameter int SUM_W = 6
) (
  input  logic [LANES*SUM_W-1:0] enc,
  output logic [LANES*SUM_W-1:0] dec
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic             sgn;
    logic [SUM_W-1:0] mag;
    assign sgn = enc[i*SUM_W + SUM_W - 1];
    assign mag = {1'b0, enc[i*SUM_W +: SUM_W-1]};
    // sign-magnitude to two's complement; negative zero folds to zero
    assign dec[i*SUM_W +: SUM_W] = sgn ? (~mag + 1'b1) : mag;
  end
endmodule

// File: rtl/pae_reduce.sv
`timescale 1ns/1ps
module pae_reduce #(
  parameter int LANES  = 4,
  parameter int SUM_W  = 6,
  parameter int CNT_W  = 6,
  parameter int TSUM_W = SUM_W + pae_pkg::grow_bits(LANES),
  parameter int TCNT_W = CNT_W + pae_pkg::grow_bits(LANES)
) (
  input  logic [LANES*SUM_W-1:0] dec,
  input  logic [LANES*CNT_W-1:0] cnt,
  output logic signed [TSUM_W-1:0] sum_total,
  output logic [TCNT_W-1:0] cnt_total
);
  always_comb begin
    sum_total = '0;
    cnt_total = '0;
    for (int i = 0; i < LANES; i++) begin
      sum_total = sum_total + TSUM_W'(signed'(dec[i*SUM_W +: SUM_W]));
      cnt_total = cnt_total + TCNT_W'(cnt[i*CNT_W +: CNT_W]);
    end
  end
endmodule

// File: rtl/pae_restoring_div.sv
`timescale 1ns/1ps
module pae_restoring_div #(
  parameter int NUM_W = 14,
  parameter int DEN_W = 8
) (
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [NUM_W-1:0] quo
);
  logic [DEN_W:0] rem;
  // one trial subtraction per quotient bit, unrolled into a single stage
  always_comb begin
    rem = '0;
    quo = '0;
    for (int i = NUM_W - 1; i >= 0; i--) begin
      rem = {rem[DEN_W-1:0], num[i]};
      if (rem >= {1'b0, den}) begin
        rem    = rem - {1'b0, den};
        quo[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/pae_phase_aggregator.sv
`timescale 1ns/1ps
module pae_phase_aggregator #(
  parameter int LANES  = 4,
  parameter int SUM_W  = 6,
  parameter int CNT_W  = 6,
  parameter int GAIN_W = 4,
  parameter int FRAC_W = 3,
  parameter int OUT_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic [LANES*SUM_W-1:0]    lane_sum,
  input  logic [LANES*CNT_W-1:0]    lane_cnt,
  input  logic [GAIN_W-1:0]         gain,
  output logic                      err_valid,
  output logic signed [OUT_W-1:0]   err_word
);
  localparam int TSUM_W = SUM_W + pae_pkg::grow_bits(LANES);
  localparam int TCNT_W = CNT_W + pae_pkg::grow_bits(LANES);
  localparam int MAG_W  = TSUM_W - 1;
  localparam int NUM_W  = MAG_W + GAIN_W + FRAC_W;
  localparam int QMAX   = 2**(OUT_W-1) - 1;

  logic [LANES*SUM_W-1:0]   dec;
  logic signed [TSUM_W-1:0] sum_total;
  logic [TCNT_W-1:0]        cnt_total;
  logic                     neg;
  logic [MAG_W-1:0]         mag;
  logic [NUM_W-1:0]         prod, num, quo;
  logic [OUT_W-1:0]         qmag;
  logic signed [OUT_W-1:0]  res;

  pae_lane_decode #(.LANES(LANES), .SUM_W(SUM_W)) u_dec (
    .enc(lane_sum), .dec(dec));

  pae_reduce #(.LANES(LANES), .SUM_W(SUM_W), .CNT_W(CNT_W),
               .TSUM_W(TSUM_W), .TCNT_W(TCNT_W)) u_red (
    .dec(dec), .cnt(lane_cnt), .sum_total(sum_total), .cnt_total(cnt_total));

  // magnitude path: |S| * G scaled by 2^FRAC_W, then divided by C
  always_comb begin
    neg  = sum_total[TSUM_W-1];
    mag  = MAG_W'(neg ? -sum_total : sum_total);
    prod = NUM_W'(mag) * NUM_W'(gain);
    num  = prod << FRAC_W;
  end

  pae_restoring_div #(.NUM_W(NUM_W), .DEN_W(TCNT_W)) u_div (
    .num(num), .den(cnt_total), .quo(quo));

  always_comb begin
    qmag = (quo > NUM_W'(QMAX)) ? OUT_W'(QMAX) : quo[OUT_W-1:0];
    if (cnt_total == '0) res = '0;
    else                 res = neg ? -signed'(qmag) : signed'(qmag);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_valid <= 1'b0;
      err_word  <= '0;
    end else begin
      err_valid <= in_valid;
      if (in_valid) err_word <= res;
    end
  end

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!err_valid && err_word == '0));
  // R8
  a_r8_valid_next: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> err_valid);
  a_r8_one_shot: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !err_valid);
  // R9
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(err_word));
  // R6
  a_r6_symmetric: assert property (@(posedge clk) disable iff (rst)
    err_valid |-> (err_word != {1'b1, {(OUT_W-1){1'b0}}}));
  // R7
  a_r7_zero_count: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_total == '0) |=> (err_valid && err_word == '0));
  // R4
  a_r4_sign: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cnt_total != '0 && sum_total > 0) |=> !err_word[OUT_W-1]);
endmodule

// File: tb/pae_phase_aggregator_test.sv
`timescale 1ns/1ps
module pae_phase_aggregator_test;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [23:0] lane_sum = '0;
  logic [23:0] lane_cnt = '0;
  logic [3:0]  gain = '0;
  logic        err_valid;
  logic signed [7:0] err_word;

  int  n_run = 0;
  int  n_bad = 0;
  bit  done  = 1'b0;
  int  res_one, res_all;

  always #2.5 clk = ~clk;

  pae_phase_aggregator uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .lane_sum(lane_sum),
    .lane_cnt(lane_cnt), .gain(gain), .err_valid(err_valid), .err_word(err_word));

  // lanes packed {lane3, lane2, lane1, lane0}; sums sign-magnitude
  localparam logic [23:0] V_SUM [NV] = '{
    {4{6'h23}},                      // -3 each
    {6'd0, 6'd0, 6'd0, 6'd2},
    {4{6'd5}},
    {6'd0, 6'd0, 6'd0, 6'd8},
    {4{6'd8}},
    {4{6'd31}},
    {4{6'h3F}},                      // -31 each
    {6'd18, 6'd31, 6'd31, 6'd31},
    {6'd19, 6'd31, 6'd31, 6'd31},
    {6'd0, 6'd0, 6'd5, 6'h20},       // lane0 negative zero
    {4{6'd3}},
    {4{6'd8}},
    {6'd0, 6'd0, 6'd0, 6'h21}        // lane0 -1
  };
  localparam logic [23:0] V_CNT [NV] = '{
    {4{6'd12}},
    {6'd0, 6'd0, 6'd0, 6'd10},
    {4{6'd25}},
    {4{6'd16}},
    {4{6'd16}},
    {4{6'd1}},
    {4{6'd1}},
    {6'd1, 6'd2, 6'd2, 6'd2},
    {6'd1, 6'd2, 6'd2, 6'd2},
    {6'd0, 6'd0, 6'd5, 6'd5},
    {4{6'd0}},
    {4{6'd16}},
    {6'd0, 6'd0, 6'd0, 6'd3}
  };
  localparam logic [3:0] V_GAIN [NV] = '{
    4'd8, 4'd4, 4'd4, 4'd8, 4'd8, 4'd15, 4'd15, 4'd1, 4'd1, 4'd8, 4'd8, 4'd0, 4'd1};
  localparam int V_EXP [NV] = '{
    -16, 6, 6, 8, 32, 127, -127, 126, 127, 32, 0, 0, -2};

  function automatic string tag(input int i);
    case (i)
      1, 2:          return "R5";
      3, 4:          return "R3";
      5, 6, 7, 8:    return "R6";
      9:             return "R2";
      10:            return "R7";
      11:            return "R10";
      default:       return "R4";
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [23:0] s, input logic [23:0] c, input logic [3:0] g);
    @(negedge clk);
    lane_sum = s; lane_cnt = c; gain = g; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid after reset", int'(err_valid), 0);
    chk("R1 word after reset", int'(err_word), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      strobe(V_SUM[i], V_CNT[i], V_GAIN[i]);
      chk("R8 valid pulse", int'(err_valid), 1);
      chk(tag(i), int'(err_word), V_EXP[i]);
      if (i == 10) chk("R7 valid on zero count", int'(err_valid), 1);
      if (i == 3) res_one = int'(err_word);
      if (i == 4) res_all = int'(err_word);
      @(negedge clk);
      chk("R8 pulse width", int'(err_valid), 0);
      repeat (5) @(negedge clk);
    end

    // R3: common shift weighs four times a single-lane one
    chk("R3 common vs single lane", res_all, 4 * res_one);

    // R9: idle-cycle stimulus must not reach the output
    strobe({4{6'd4}}, {4{6'd8}}, 4'd4);      // S=16 C=32 G=4 -> 16
    chk("R4 reference", int'(err_word), 16);
    @(negedge clk);
    lane_sum = {4{6'h3F}}; lane_cnt = {4{6'd1}}; gain = 4'd15;
    repeat (3) begin
      @(negedge clk);
      chk("R9 valid stays low", int'(err_valid), 0);
      chk("R9 word held", int'(err_word), 16);
    end

    // R1: reset mid-run clears the held word
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 word after mid-run reset", int'(err_word), 0);
    chk("R1 valid after mid-run reset", int'(err_valid), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end
endmodule